// File: doc/BRIEF.md
# Label-Filtered Receive Word Queue

This block sits behind a serial line decoder that has already assembled a 32-bit avionics data word. When the decoder raises its end-of-word strobe, the block decides whether the word is worth keeping. Two checks can be switched on. The first looks up the word's 8-bit label in a 256-entry enable bitmap. The second compares the two identifier bits that follow the label against a pair of reference bits. Only words that pass every enabled check are queued. A word that is turned away changes nothing that can be observed.

Accepted words wait in a 32-entry queue until a host reads them. The queue always presents its oldest word, and the label byte of that word can be bit-reversed on the way out. Empty, half-full and full flags are derived from the occupancy. One more output, the service flag, follows either the empty flag or the full flag, as chosen by a control input. When the queue is full and nothing is read, a newly accepted word replaces the newest stored word, so the older backlog is kept. A master clear empties the queue. The control bits and the label bitmap come from a register block outside this block and are plain inputs here.

Top module: `arx_label_fifo`

## Requirements
- R1: When `lbl_chk_en` is 1, a strobed word is queued only if `lbl_table[word_in[7:0]]` is 1. When `lbl_chk_en` is 0, the label plays no part in the decision.
- R2: When `id_chk_en` is 1, a strobed word is queued only if `word_in[9]` equals `id_ref10` and `word_in[8]` equals `id_ref9`. When `id_chk_en` is 0, these bits are not examined.
- R3: A strobed word that fails an enabled check leaves the flags, the occupancy and `rd_data` exactly as they were.
- R4: Queued words leave in arrival order. `rd_data` shows the oldest word, and a `rd_en` pulse removes it. The flags change after the clock edge that samples the strobe or the read.
- R5: `empty` is 1 when no word is held. While `empty` is 1, `rd_data` is all zeros and `rd_en` has no effect.
- R6: `half_full` is 1 exactly when the queue holds 16 or more words.
- R7: `full` is 1 when 32 words are held. An accepted word that arrives while the queue is full and no read is requested replaces the most recently stored word. The occupancy stays at 32, and the oldest word stays at the head.
- R8: When an accepted word and a read arrive in the same cycle while the queue is full, the oldest word is removed and the new word is appended. The queue stays full.
- R9: `rflag` equals `empty` when `flag_sel` is 0 and equals `full` when `flag_sel` is 1.
- R10: When `lbl_swap` is 1, `rd_data[7:0]` is the bit-reverse of the stored label byte: bit i comes from stored bit 7-i. Bits 31:8 are unaffected. When `lbl_swap` is 0, the word appears as stored.
- R11: A `mreset` pulse empties the queue on the next clock edge. It takes priority over a strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mreset | input | 1 | Synchronous master clear of the queue |
| eos | input | 1 | End-of-word strobe, one cycle per decoded word |
| word_in | input | 32 | Decoded word; bits 7:0 label, 9:8 identifier bits |
| lbl_table | input | 256 | Label enable bitmap, one bit per label value |
| lbl_chk_en | input | 1 | Enable label bitmap check |
| id_chk_en | input | 1 | Enable identifier bit check |
| id_ref10 | input | 1 | Required value of word bit 9 |
| id_ref9 | input | 1 | Required value of word bit 8 |
| lbl_swap | input | 1 | Present label byte bit-reversed on read |
| flag_sel | input | 1 | Service flag source: 0 empty, 1 full |
| rd_en | input | 1 | Remove the head word |
| rd_data | output | 32 | Head word, zero when empty |
| empty | output | 1 | No words held |
| half_full | output | 1 | 16 or more words held |
| full | output | 1 | 32 words held |
| rflag | output | 1 | Service flag selected by `flag_sel` |

## Verification
The bench targets the full-queue corners first. A design that dropped the word, overwrote the oldest entry, or let the occupancy climb past 32 would show the wrong word at the end of a full drain. The same drain catches a design that handled a simultaneous accept and read while full as a plain overwrite, because that design would keep a stale head. Rejected words are pushed into a non-empty queue. A design that wrote them anyway, or advanced a pointer, would reveal an extra or shifted word. The bench also reads an empty queue and then queues a word, and checks the cycle after a master clear that collides with a strobe. Pointer corruption in either case shows up as a wrong head word.

// File: rtl/arx_pkg.sv
package arx_pkg;

  // acceptance checks configuration
  typedef struct packed {
    logic lbl_en;
    logic id_en;
    logic id_b10;
    logic id_b9;
  } arx_filt_t;

  // queue operation chosen each cycle
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_PUSH,
    OP_POP,
    OP_SWAP,
    OP_OVER,
    OP_CLEAR
  } arx_op_e;

endpackage

// File: rtl/arx_accept.sv
module arx_accept
  import arx_pkg::*;
#(
  parameter int LBL_W = 8
) (
  input  logic [LBL_W+1:0]       word_i,
  input  logic                   eos_i,
  input  arx_filt_t              cfg_i,
  input  logic [(1<<LBL_W)-1:0]  tbl_i,
  output logic                   keep_o
);

  logic [LBL_W-1:0] idx;
  logic             lbl_ok;
  logic             id_ok;

  assign idx = word_i[LBL_W-1:0];

  always_comb begin
    lbl_ok = !cfg_i.lbl_en || tbl_i[idx];
    id_ok  = !cfg_i.id_en ||
             ((word_i[LBL_W+1] == cfg_i.id_b10) && (word_i[LBL_W] == cfg_i.id_b9));
    keep_o = eos_i && lbl_ok && id_ok;
  end

endmodule

// File: rtl/arx_store.sv
module arx_store
  import arx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic              pop_req_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] head_o,
  output logic [CW-1:0]     count_o
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     rd_q, rd_d, wr_q, wr_d, wa;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              we;
  logic              st_en;
  logic              is_empty, is_full;
  arx_op_e           op;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [AW-1:0] ptr_dec(input logic [AW-1:0] p);
    return (p == '0) ? AW'(DEPTH - 1) : p - 1'b1;
  endfunction

  assign is_empty = (cnt_q == '0);
  assign is_full  = (cnt_q == CW'(DEPTH));

  // operation decode
  always_comb begin
    if (clr_i)                              op = OP_CLEAR;
    else if (push_i && pop_req_i && !is_empty) op = OP_SWAP;
    else if (push_i && is_full)             op = OP_OVER;
    else if (push_i)                        op = OP_PUSH;
    else if (pop_req_i && !is_empty)        op = OP_POP;
    else                                    op = OP_IDLE;
  end

  // next state
  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    wa    = wr_q;
    we    = 1'b0;
    unique case (op)
      OP_CLEAR: begin
        rd_d  = '0;
        wr_d  = '0;
        cnt_d = '0;
      end
      OP_SWAP: begin
        we   = 1'b1;
        wr_d = ptr_inc(wr_q);
        rd_d = ptr_inc(rd_q);
      end
      OP_OVER: begin
        we = 1'b1;
        wa = ptr_dec(wr_q);
      end
      OP_PUSH: begin
        we    = 1'b1;
        wr_d  = ptr_inc(wr_q);
        cnt_d = cnt_q + 1'b1;
      end
      OP_POP: begin
        rd_d  = ptr_inc(rd_q);
        cnt_d = cnt_q - 1'b1;
      end
      default: ;
    endcase
  end

  assign st_en = (op != OP_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (st_en) begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= data_i;
  end

  assign head_o  = is_empty ? '0 : mem[rd_q];
  assign count_o = cnt_q;

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R5
  ptr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_empty |-> (rd_q == wr_q));

  // R7
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_req_i && is_full && !clr_i) |=> (is_full && $stable(rd_q) && $stable(wr_q)));

  // R8
  swap_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_req_i && is_full && !clr_i) |=> (is_full && (rd_q != $past(rd_q))));

  // R11
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> is_empty);

endmodule

// File: rtl/arx_view.sv
module arx_view #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  parameter int LBL_W  = 8,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int HALF  = DEPTH / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] head_i,
  input  logic [CW-1:0]     count_i,
  input  logic              lbl_rev_i,
  input  logic              flag_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              empty_o,
  output logic              half_o,
  output logic              full_o,
  output logic              rflag_o
);

  logic [LBL_W-1:0] rev_lbl;

  for (genvar g = 0; g < LBL_W; g++) begin : g_rev
    assign rev_lbl[g] = head_i[LBL_W-1-g];
  end

  always_comb begin
    empty_o   = (count_i == '0);
    half_o    = (count_i >= CW'(HALF));
    full_o    = (count_i == CW'(DEPTH));
    rflag_o   = flag_sel_i ? full_o : empty_o;
    rd_data_o = {head_i[DATA_W-1:LBL_W], lbl_rev_i ? rev_lbl : head_i[LBL_W-1:0]};
  end

  // R6
  full_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> half_o);

  // R5
  empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty_o |-> (rd_data_o == '0));

endmodule

// File: rtl/arx_label_fifo.sv
module arx_label_fifo
  import arx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  parameter int LBL_W  = 8,
  localparam int TBL_N = 1 << LBL_W,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mreset,
  input  logic              eos,
  input  logic [DATA_W-1:0] word_in,
  input  logic [TBL_N-1:0]  lbl_table,
  input  logic              lbl_chk_en,
  input  logic              id_chk_en,
  input  logic              id_ref10,
  input  logic              id_ref9,
  input  logic              lbl_swap,
  input  logic              flag_sel,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              half_full,
  output logic              full,
  output logic              rflag
);

  arx_filt_t         filt;
  logic              keep;
  logic [DATA_W-1:0] head;
  logic [CW-1:0]     count;

  assign filt = '{lbl_en: lbl_chk_en, id_en: id_chk_en, id_b10: id_ref10, id_b9: id_ref9};

  arx_accept #(.LBL_W(LBL_W)) u_accept (
    .word_i (word_in[LBL_W+1:0]),
    .eos_i  (eos),
    .cfg_i  (filt),
    .tbl_i  (lbl_table),
    .keep_o (keep)
  );

  arx_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (mreset),
    .push_i    (keep),
    .pop_req_i (rd_en),
    .data_i    (word_in),
    .head_o    (head),
    .count_o   (count)
  );

  arx_view #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LBL_W(LBL_W)) u_view (
    .clk        (clk),
    .rst_n      (rst_n),
    .head_i     (head),
    .count_i    (count),
    .lbl_rev_i  (lbl_swap),
    .flag_sel_i (flag_sel),
    .rd_data_o  (rd_data),
    .empty_o    (empty),
    .half_o     (half_full),
    .full_o     (full),
    .rflag_o    (rflag)
  );

  // R3
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eos && !keep && !rd_en && !mreset) |=> $stable(count));

  // R1
  lbl_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eos && lbl_chk_en && !lbl_table[word_in[LBL_W-1:0]] && !rd_en && !mreset) |=> $stable(count));

endmodule

// File: tb/sim_arx_label_fifo.sv
`timescale 1ns/1ps
module sim_arx_label_fifo;

  logic        clk = 1'b0;
  logic        rst_n, mreset, eos, rd_en;
  logic [31:0] word_in;
  logic [255:0] lbl_table;
  logic        lbl_chk_en, id_chk_en, id_ref10, id_ref9, lbl_swap, flag_sel;
  logic [31:0] rd_data;
  logic        empty, half_full, full, rflag;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  arx_label_fifo u0 (
    .clk(clk), .rst_n(rst_n), .mreset(mreset), .eos(eos), .word_in(word_in),
    .lbl_table(lbl_table), .lbl_chk_en(lbl_chk_en), .id_chk_en(id_chk_en),
    .id_ref10(id_ref10), .id_ref9(id_ref9), .lbl_swap(lbl_swap), .flag_sel(flag_sel),
    .rd_en(rd_en), .rd_data(rd_data), .empty(empty), .half_full(half_full),
    .full(full), .rflag(rflag)
  );

  // {lbl_chk_en, id_chk_en, id_ref10, id_ref9, word, expect_kept}
  localparam logic [36:0] VEC [9] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 32'h1234_5602, 1'b1},
    {1'b1, 1'b0, 1'b0, 1'b0, 32'h1234_5602, 1'b0},
    {1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_0A03, 1'b1},
    {1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_0201, 1'b1},
    {1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_0101, 1'b0},
    {1'b0, 1'b1, 1'b0, 1'b1, 32'h0000_0101, 1'b1},
    {1'b1, 1'b1, 1'b1, 1'b1, 32'hABC0_0305, 1'b1},
    {1'b1, 1'b1, 1'b1, 1'b1, 32'hABC0_0304, 1'b0},
    {1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_0305, 1'b0}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    word_in = w;
    eos     = 1'b1;
    @(negedge clk);
    eos     = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic push_pop(input logic [31:0] w);
    @(negedge clk);
    word_in = w;
    eos     = 1'b1;
    rd_en   = 1'b1;
    @(negedge clk);
    eos     = 1'b0;
    rd_en   = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R4 watchdog act=%h exp=%h", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mreset = 1'b0; eos = 1'b0; rd_en = 1'b0; word_in = '0;
    lbl_chk_en = 1'b0; id_chk_en = 1'b0; id_ref10 = 1'b0; id_ref9 = 1'b0;
    lbl_swap = 1'b0; flag_sel = 1'b0;
    for (int i = 0; i < 256; i++) lbl_table[i] = i[0];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    check(empty == 1'b1, "R5 reset empty", {31'd0, empty}, 32'd1);
    check(rd_data == 32'd0, "R5 reset data", rd_data, 32'd0);
    check(half_full == 1'b0 && full == 1'b0, "R6 reset half/full", {30'd0, half_full, full}, 32'd0);
    check(rflag == 1'b1, "R9 reset rflag", {31'd0, rflag}, 32'd1);

    // acceptance vector table (R1, R2)
    for (int v = 0; v < 9; v++) begin
      lbl_chk_en = VEC[v][36];
      id_chk_en  = VEC[v][35];
      id_ref10   = VEC[v][34];
      id_ref9    = VEC[v][33];
      push(VEC[v][32:1]);
      if (VEC[v][0]) begin
        check(empty == 1'b0 && rd_data == VEC[v][32:1], VEC[v][35] ? "R2 kept" : "R1 kept",
              rd_data, VEC[v][32:1]);
        pop();
        check(empty == 1'b1, "R4 drained", {31'd0, empty}, 32'd1);
      end else begin
        check(empty == 1'b1 && rd_data == 32'd0, VEC[v][35] ? "R2 dropped" : "R1 dropped",
              rd_data, 32'd0);
      end
    end

    // rejected word into non-empty queue (R3)
    lbl_chk_en = 1'b1; id_chk_en = 1'b0;
    push(32'h7777_0011);
    push(32'h8888_0022);
    check(rd_data == 32'h7777_0011 && empty == 1'b0 && half_full == 1'b0,
          "R3 head unchanged", rd_data, 32'h7777_0011);
    pop();
    check(empty == 1'b1, "R3 nothing extra queued", {31'd0, empty}, 32'd1);
    lbl_chk_en = 1'b0;

    // pop on empty then push (R5)
    pop();
    push(32'hCAFE_0001);
    check(rd_data == 32'hCAFE_0001, "R5 empty pop ignored", rd_data, 32'hCAFE_0001);
    pop();

    // fill (R6, R7, R9)
    for (int k = 0; k < 32; k++) begin
      push(32'h5000_0000 + k);
      if (k == 14) check(half_full == 1'b0, "R6 15 words", {31'd0, half_full}, 32'd0);
      if (k == 15) check(half_full == 1'b1, "R6 16 words", {31'd0, half_full}, 32'd1);
      if (k == 30) check(full == 1'b0, "R7 31 words", {31'd0, full}, 32'd0);
    end
    check(full == 1'b1, "R7 full at 32", {31'd0, full}, 32'd1);
    check(rflag == 1'b0, "R9 rflag empty src", {31'd0, rflag}, 32'd0);
    @(negedge clk);
    flag_sel = 1'b1;
    #1;
    check(rflag == 1'b1, "R9 rflag full src", {31'd0, rflag}, 32'd1);

    // push and pop together while full (R8)
    push_pop(32'h0000_0100);
    check(full == 1'b1 && rd_data == 32'h5000_0001, "R8 swap head", rd_data, 32'h5000_0001);

    // push while full, no pop (R7)
    push(32'h0000_0200);
    check(full == 1'b1 && rd_data == 32'h5000_0001, "R7 overwrite keeps head", rd_data, 32'h5000_0001);

    // drain in order
    for (int k = 1; k <= 31; k++) begin
      check(rd_data == 32'h5000_0000 + k, "R4 order", rd_data, 32'h5000_0000 + k);
      pop();
      if (k == 16) check(half_full == 1'b1, "R6 back to 16", {31'd0, half_full}, 32'd1);
      if (k == 17) check(half_full == 1'b0, "R6 down to 15", {31'd0, half_full}, 32'd0);
    end
    check(rd_data == 32'h0000_0200, "R7 newest replaced", rd_data, 32'h0000_0200);
    pop();
    check(empty == 1'b1, "R5 drained empty", {31'd0, empty}, 32'd1);
    flag_sel = 1'b0;

    // label reversal (R10)
    push(32'hDEAD_BE01);
    lbl_swap = 1'b1;
    #1;
    check(rd_data == 32'hDEAD_BE80, "R10 reversed", rd_data, 32'hDEAD_BE80);
    lbl_swap = 1'b0;
    #1;
    check(rd_data == 32'hDEAD_BE01, "R10 as stored", rd_data, 32'hDEAD_BE01);
    pop();

    // master clear colliding with a strobe (R11)
    push(32'h1111_0001);
    push(32'h1111_0002);
    @(negedge clk);
    mreset  = 1'b1;
    eos     = 1'b1;
    word_in = 32'h1111_0003;
    @(negedge clk);
    mreset  = 1'b0;
    eos     = 1'b0;
    check(empty == 1'b1 && rd_data == 32'd0, "R11 cleared", rd_data, 32'd0);
    push(32'h2222_0004);
    check(rd_data == 32'h2222_0004, "R11 clean restart", rd_data, 32'h2222_0004);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule